// File: doc/BRIEF.md
# EEPROM Page Write Sequencer

This block sits behind a serial-bus slave engine in a 2 K × 8 non-volatile memory. The engine decodes the bus and hands it a small set of events. A new write instruction carries its start address. Each data byte arrives as a one-cycle strobe together with the level of the write-protect pin. A bus Stop arrives as a pulse, and a qualifier pulse marks a Stop that falls in the slot straight after a data byte's acknowledge. The sequencer gathers the bytes of one instruction into a 16-byte page latch and keeps a per-offset valid mask. When the instruction ends correctly, it runs one internal write cycle of a fixed number of system clocks.

During the write cycle the sequencer drives the array's write strobes once for each latched offset, in ascending order. Offsets that were never latched are not touched. It holds `busy` for the whole cycle and ignores the bus engine while it does. When the cycle ends, the address counter it exposes points one past the last modified byte. That pointer wraps inside the page, as the byte pointer does while bytes are collected.

Top module: `eeprom_page_writer`

## Requirements
- R1: The start address splits into a page number (bits 10..4) and an in-page offset (bits 3..0). Each accepted data byte is latched at the current offset, and the offset then increments by one.
- R2: After offset 15 the offset wraps to 0 of the same page. A byte that lands on an offset already latched replaces the earlier byte.
- R3: A write cycle starts only when `stop_any` and `stop_commit` are both high while an instruction is open and at least one byte is latched. A `stop_any` without `stop_commit` closes the instruction without any write. A Stop while no instruction is open has no effect.
- R4: `busy` rises in the cycle after the committing Stop and stays high for exactly `WRITE_CYCLES` clock cycles.
- R5: While `busy` is high, `instr_start` and `byte_stb` are ignored. The address counter is not reloaded, no byte is latched, and no instruction is opened.
- R6: During a write cycle, `arr_we` pulses once for each latched offset, in ascending offset order. Each pulse carries `arr_addr` = {page, offset} and the latched byte on `arr_wdata`. `arr_we` is never high outside a write cycle.
- R7: `addr_cnt` takes the start address on an accepted `instr_start`. In the cycle after `busy` falls it holds {page, (last latched offset + 1) mod 16}, so offset 15 leads to offset 0 of the same page. It holds its value while `busy` is high.
- R8: A byte strobe with `wr_lock` high is not latched and does not move the offset. An instruction whose bytes were all locked starts no write cycle.
- R9: After synchronous reset, `busy` and `arr_we` are low and `addr_cnt` is zero.
- R10: An accepted `instr_start` clears the valid mask. Bytes from an earlier instruction that was never committed are not written by a later commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_start | input | 1 | Pulse: new write instruction, load start address |
| start_addr | input | 11 | Start address of the instruction |
| byte_stb | input | 1 | Pulse: one data byte received |
| byte_data | input | 8 | Data byte that goes with `byte_stb` |
| wr_lock | input | 1 | Write-protect level; high blocks latching |
| stop_any | input | 1 | Pulse: bus Stop seen |
| stop_commit | input | 1 | Pulse with `stop_any`: Stop came right after a data acknowledge |
| busy | output | 1 | Internal write cycle in progress |
| addr_cnt | output | 11 | Internal address counter |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | 11 | Array byte address |
| arr_wdata | output | 8 | Array byte data |

## Verification
The assertions check on every cycle that array strobes occur only inside a write cycle and that the controller's write state agrees with the timer's busy flag. They also check that the cycle counter never passes its limit, that the address counter holds still until the cycle ends, that a locked byte never changes the valid mask, and that a cycle never starts with an empty mask. Only the bench's scenarios show which bytes reach the array, in which order and at which addresses. The same holds for in-page wrap and overwrite, the exact cycle length, the final pointer (including the wrap from offset 15), and whether a Stop in the wrong slot, a repeated start or an intrusion during busy is dropped.

// File: rtl/pws_pkg.sv
package pws_pkg;

    localparam int unsigned ADDR_W     = 11;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned OFF_W      = 4;
    localparam int unsigned PAGE_BYTES = 1 << OFF_W;
    localparam int unsigned PAGE_W     = ADDR_W - OFF_W;

    typedef logic [ADDR_W-1:0]     addr_t;
    typedef logic [DATA_W-1:0]     data_t;
    typedef logic [OFF_W-1:0]      off_t;
    typedef logic [PAGE_W-1:0]     page_t;
    typedef logic [PAGE_BYTES-1:0] mask_t;

    typedef struct packed {
        page_t page;
        off_t  off;
    } loc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_WRITING
    } seq_state_e;

    function automatic loc_t to_loc(addr_t a);
        return loc_t'(a);
    endfunction

    function automatic off_t bump_off(off_t o);
        return o + off_t'(1);
    endfunction

endpackage

// File: rtl/pws_page_latch.sv
module pws_page_latch
    import pws_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t load_addr,
    input  logic  accept,
    input  data_t wdata,
    input  off_t  rd_off,
    output mask_t mask,
    output page_t page,
    output off_t  ptr,
    output data_t rd_data
);

    data_t slot [PAGE_BYTES];
    loc_t  ld;

    assign ld = to_loc(load_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            page <= '0;
            ptr  <= '0;
        end else if (load) begin
            mask <= '0;
            page <= ld.page;
            ptr  <= ld.off;
        end else if (accept) begin
            mask[ptr] <= 1'b1;
            ptr       <= bump_off(ptr);
        end
    end

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[i] <= '1;
            end else if (accept && !load && ptr == off_t'(i)) begin
                slot[i] <= wdata;
            end
        end
    end

    assign rd_data = slot[rd_off];

endmodule

// File: rtl/pws_cycle_timer.sv
module pws_cycle_timer #(
    parameter int unsigned WRITE_CYCLES = 40
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 start,
    output logic                                 busy,
    output logic                                 done,
    output logic [$clog2(WRITE_CYCLES+1)-1:0]    cnt
);

    localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

    assign done = busy && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    p_cnt_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LAST))
        else $error("timer count beyond cycle length");

endmodule

// File: rtl/pws_ctrl.sv
module pws_ctrl
    import pws_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic instr_start,
    input  logic byte_stb,
    input  logic wr_lock,
    input  logic stop_any,
    input  logic stop_commit,
    input  logic has_bytes,
    input  logic busy,
    input  logic done,
    output logic load,
    output logic accept,
    output logic commit
);

    seq_state_e state, state_nx;

    always_comb begin
        load     = 1'b0;
        accept   = 1'b0;
        commit   = 1'b0;
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (instr_start) begin
                    load     = 1'b1;
                    state_nx = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (stop_any) begin
                    if (stop_commit && has_bytes) begin
                        commit   = 1'b1;
                        state_nx = ST_WRITING;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end else if (instr_start) begin
                    load = 1'b1;
                end else if (byte_stb && !wr_lock) begin
                    accept = 1'b1;
                end
            end
            ST_WRITING: begin
                if (done) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    p_state_busy_agree_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITING) == busy)
        else $error("controller state and timer busy disagree");

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import pws_pkg::*;
#(
    parameter int unsigned WRITE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              wr_lock,
    input  logic              stop_any,
    input  logic              stop_commit,
    output logic              busy,
    output logic [ADDR_W-1:0] addr_cnt,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);

    localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);

    if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_len
        $error("WRITE_CYCLES must cover one strobe per page offset");
    end

    logic             load, accept, commit, done;
    logic [CNT_W-1:0] cnt;
    mask_t            mask;
    page_t            page;
    off_t             ptr, scan;
    data_t            rd_data;
    loc_t             wr_loc;

    pws_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .instr_start (instr_start),
        .byte_stb    (byte_stb),
        .wr_lock     (wr_lock),
        .stop_any    (stop_any),
        .stop_commit (stop_commit),
        .has_bytes   (|mask),
        .busy        (busy),
        .done        (done),
        .load        (load),
        .accept      (accept),
        .commit      (commit)
    );

    pws_page_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (start_addr),
        .accept    (accept),
        .wdata     (byte_data),
        .rd_off    (scan),
        .mask      (mask),
        .page      (page),
        .ptr       (ptr),
        .rd_data   (rd_data)
    );

    pws_cycle_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (commit),
        .busy  (busy),
        .done  (done),
        .cnt   (cnt)
    );

    // Commit walk: the first PAGE_BYTES cycles of the timer visit offsets 0..15.
    assign scan        = cnt[OFF_W-1:0];
    assign wr_loc.page = page;
    assign wr_loc.off  = scan;
    assign arr_we      = busy && (cnt < CNT_W'(PAGE_BYTES)) && mask[scan];
    assign arr_addr    = addr_t'(wr_loc);
    assign arr_wdata   = rd_data;

    always_ff @(posedge clk) begin
        if (rst)       addr_cnt <= '0;
        else if (done) addr_cnt <= {page, ptr};
        else if (load) addr_cnt <= start_addr;
    end

    p_we_in_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy)
        else $error("array strobe outside write cycle");

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(addr_cnt))
        else $error("address counter moved during write cycle");

    p_locked_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (byte_stb && wr_lock && !instr_start) |=> $stable(mask))
        else $error("locked byte changed the valid mask");

    p_commit_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mask != '0))
        else $error("write cycle with empty page latch");

endmodule

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WR_CYC     = 40;

    typedef struct packed {
        logic [10:0] a;
        logic [7:0]  d;
    } wr_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_start = 1'b0;
    logic [10:0] start_addr = '0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        wr_lock = 1'b0;
    logic        stop_any = 1'b0;
    logic        stop_commit = 1'b0;
    logic        busy, arr_we;
    logic [10:0] addr_cnt, arr_addr;
    logic [7:0]  arr_wdata;

    int checks = 0;
    int fails  = 0;

    wr_t exp_q[$];

    logic [15:0] m_mask;
    logic [7:0]  m_data [16];
    logic [6:0]  m_page;
    logic [3:0]  m_ptr;
    logic        m_open = 1'b0;
    logic [10:0] m_cnt = '0;

    eeprom_page_writer #(.WRITE_CYCLES(WR_CYC)) uut (
        .clk(clk), .rst(rst), .instr_start(instr_start), .start_addr(start_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .wr_lock(wr_lock),
        .stop_any(stop_any), .stop_commit(stop_commit), .busy(busy),
        .addr_cnt(addr_cnt), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected array writes as the design issues them.
    always @(negedge clk) begin
        if (!rst && arr_we) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected write addr", {21'd0, arr_addr}, 32'hFFFF_FFFF);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                check("R6 write addr", {21'd0, arr_addr}, {21'd0, e.a});
                check("R6 write data", {24'd0, arr_wdata}, {24'd0, e.d});
            end
        end
    end

    task automatic start_instr(input logic [10:0] a);
        instr_start = 1'b1;
        start_addr  = a;
        @(negedge clk);
        instr_start = 1'b0;
        m_mask = '0;
        m_page = a[10:4];
        m_ptr  = a[3:0];
        m_open = 1'b1;
        m_cnt  = a;
        check("R7 addr_cnt load", {21'd0, addr_cnt}, {21'd0, m_cnt});
    endtask

    task automatic send_byte(input logic [7:0] d, input logic lock);
        byte_stb  = 1'b1;
        byte_data = d;
        wr_lock   = lock;
        @(negedge clk);
        byte_stb = 1'b0;
        wr_lock  = 1'b0;
        if (m_open && !lock) begin
            m_data[m_ptr] = d;
            m_mask[m_ptr] = 1'b1;
            m_ptr = m_ptr + 4'd1;
        end
    endtask

    task automatic stop(input logic qual, input logic intrude);
        logic go;
        int n;
        go = m_open && qual && (m_mask != 0);
        if (go) begin
            for (int o = 0; o < 16; o++)
                if (m_mask[o]) exp_q.push_back({m_page, 4'(o), m_data[o]});
        end
        stop_any    = 1'b1;
        stop_commit = qual;
        @(negedge clk);
        stop_any    = 1'b0;
        stop_commit = 1'b0;
        m_open      = 1'b0;
        if (go) begin
            n = 0;
            while (busy && n < 1000) begin
                n++;
                if (intrude && n == 3) begin
                    instr_start = 1'b1; start_addr = 11'h7FF;
                    byte_stb = 1'b1; byte_data = 8'h00;
                end else begin
                    instr_start = 1'b0; byte_stb = 1'b0;
                end
                if (n < WR_CYC)
                    check("R7 addr_cnt held while busy", {21'd0, addr_cnt}, {21'd0, m_cnt});
                @(negedge clk);
            end
            instr_start = 1'b0;
            byte_stb    = 1'b0;
            check("R4 busy length", n, WR_CYC);
            m_cnt = {m_page, m_ptr};
            check("R7 addr_cnt after cycle", {21'd0, addr_cnt}, {21'd0, m_cnt});
            check("R6 all writes issued", exp_q.size(), 0);
        end else begin
            repeat (3) begin
                check("R3 no cycle started", {31'd0, busy}, 0);
                @(negedge clk);
            end
            check("R3 addr_cnt unchanged", {21'd0, addr_cnt}, {21'd0, m_cnt});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9 busy after reset", {31'd0, busy}, 0);
        check("R9 addr_cnt after reset", {21'd0, addr_cnt}, 0);
        check("R9 arr_we after reset", {31'd0, arr_we}, 0);

        // R1 single byte
        start_instr(11'h123);
        send_byte(8'hA5, 1'b0);
        stop(1'b1, 1'b0);

        // R1 several bytes from a page start
        start_instr(11'h0A0);
        for (int i = 0; i < 5; i++) send_byte(8'h10 + 8'(i), 1'b0);
        stop(1'b1, 1'b0);

        // R2 wrap inside page
        start_instr(11'h2FD);
        for (int i = 0; i < 5; i++) send_byte(8'h60 + 8'(i), 1'b0);
        stop(1'b1, 1'b0);

        // R2 overwrite after full page
        start_instr(11'h150);
        for (int i = 0; i < 18; i++) send_byte(8'h80 + 8'(i), 1'b0);
        stop(1'b1, 1'b0);

        // R7 last byte at offset 15 wraps pointer to offset 0
        start_instr(11'h40F);
        send_byte(8'h3C, 1'b0);
        stop(1'b1, 1'b0);

        // R3 Stop in the wrong slot discards
        start_instr(11'h300);
        send_byte(8'h11, 1'b0);
        send_byte(8'h22, 1'b0);
        stop(1'b0, 1'b0);

        // R3 Stop with qualifier while idle does nothing
        stop(1'b1, 1'b0);

        // R8 all bytes locked
        start_instr(11'h310);
        send_byte(8'h44, 1'b1);
        send_byte(8'h55, 1'b1);
        stop(1'b1, 1'b0);

        // R8 mixed locking: locked byte skipped, offset not moved
        start_instr(11'h320);
        send_byte(8'h01, 1'b0);
        send_byte(8'h02, 1'b1);
        send_byte(8'h03, 1'b0);
        stop(1'b1, 1'b0);

        // R10 repeated start clears earlier bytes
        start_instr(11'h500);
        send_byte(8'hDE, 1'b0);
        send_byte(8'hAD, 1'b0);
        start_instr(11'h508);
        send_byte(8'hBE, 1'b0);
        stop(1'b1, 1'b0);

        // R5 intrusion during busy is ignored
        start_instr(11'h6A2);
        send_byte(8'h77, 1'b0);
        send_byte(8'h78, 1'b0);
        stop(1'b1, 1'b1);
        stop(1'b1, 1'b0);
        check("R5 no latched write from intrusion", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule